// File: doc/BRIEF.md
# Write-Through Store Drain Buffer

This block sits between a write-through cache and a slow memory. Every store the processor issues is written into the cache array and, in the same cycle, offered to this block as a word address, up to 16 bits of data and a byte-lane mask. Accepted stores wait in a small first-in first-out queue. A drain state machine presents the oldest entry to memory and keeps it there until memory acknowledges, which may take many cycles. The processor is held back only when every slot is occupied.

Loads that the cache serves can look up the same address in the queue. For each byte lane, the lookup returns the byte from the youngest queued store to that word that wrote the lane, along with a mask of the lanes it found. The processor merges those bytes over the cache or memory data. The drain machine has two states. `DR_IDLE` means nothing is being offered. `DR_BUSY` means the head entry is on the memory port. The transition `go_busy` (IDLE to BUSY) fires when a store is accepted. The transition `go_idle` (BUSY to IDLE) fires when the last entry is acknowledged and no store arrives in that cycle. In all other cases BUSY holds and moves on to the next entry after each acknowledge.

Top module: `store_wbuf`

## Requirements
- R1: While reset is low and just after it, the queue is empty: `mem_req` is 0, `st_stall` is 0 and `rd_mask` is 0.
- R2: Entries are written to memory one at a time, in exactly the order the stores were accepted, with `mem_addr` equal to the store's word address.
- R3: While `mem_req` is 1 and `mem_ack` is 0, the head entry stays on `mem_addr`, `mem_data` and `mem_be` unchanged. An entry leaves the queue only in a cycle where `mem_req` and `mem_ack` are both 1.
- R4: `st_stall` is 1 exactly when all DEPTH slots (4 by default) hold entries and no acknowledge is taken in that cycle. A store with `st_valid` 1 and `st_stall` 0 is accepted, and a stalled store is not queued.
- R5: Each entry keeps its store's byte mask unchanged. Bit i of `mem_be` enables data bits [8i+7:8i].
- R6: When a store is accepted into an empty queue, `mem_req` is 1 on the following cycle.
- R7: `rd_mask` bit i is 1 when some queued entry has address `rd_addr` and bit i set in its mask. The matching lane of `rd_data` then carries that lane from the youngest such entry. Lanes with no match read 0. The lookup is combinational.
- R8: When the queue is full and a store arrives in the same cycle as an acknowledge, the store is accepted (`st_stall` 0) and the queue stays full.
- R9: `mem_req` is 1 exactly when the queue holds at least one entry. It falls the cycle after the last acknowledge if no store was accepted with that acknowledge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Processor store present |
| st_addr | input | AW | Store word address |
| st_data | input | DW | Store data |
| st_be | input | DW/8 | Store byte-lane mask |
| st_stall | output | 1 | Store not accepted this cycle |
| rd_addr | input | AW | Load word address for queue lookup |
| rd_data | output | DW | Forwarded bytes from queued stores |
| rd_mask | output | DW/8 | Lanes supplied by queued stores |
| mem_req | output | 1 | Head entry offered to memory |
| mem_addr | output | AW | Head entry address |
| mem_data | output | DW | Head entry data |
| mem_be | output | DW/8 | Head entry byte mask |
| mem_ack | input | 1 | Memory has taken the head entry |

## Verification
Three results have different timing. `st_stall` and the forwarding outputs `rd_data`/`rd_mask` are combinational, so they are due in the same cycle as the inputs that cause them. The memory port outputs and the queue occupancy react one clock edge after a push or an acknowledge. The bench drives every input at the falling edge and waits a short delay before sampling. It compares the combinational outputs against a reference queue as it stood before that cycle's edge. It then updates the reference with the edge's push and pop, so the registered outputs are checked one cycle later, after exactly one register stage.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;

    typedef enum logic [0:0] {
        DR_IDLE = 1'b0,
        DR_BUSY = 1'b1
    } drain_state_t;

endpackage

// File: rtl/wbuf_fifo.sv
module wbuf_fifo #(
    parameter int DEPTH = 4,
    parameter int AW    = 32,
    parameter int DW    = 16,
    localparam int BW   = DW / 8,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic [AW-1:0] in_addr,
    input  logic [DW-1:0] in_data,
    input  logic [BW-1:0] in_be,
    output logic [AW-1:0] head_addr,
    output logic [DW-1:0] head_data,
    output logic [BW-1:0] head_be,
    output logic [CW-1:0] occ,
    output logic [PW-1:0] rd_ptr,
    output logic [AW-1:0] e_addr [DEPTH],
    output logic [DW-1:0] e_data [DEPTH],
    output logic [BW-1:0] e_be   [DEPTH]
);

    logic [PW-1:0] wr_ptr;

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (push && (wr_ptr == PW'(i))) begin
                e_addr[i] <= in_addr;
                e_data[i] <= in_data;
                e_be[i]   <= in_be;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            occ    <= '0;
        end else begin
            if (push) wr_ptr <= wr_ptr + PW'(1);
            if (pop)  rd_ptr <= rd_ptr + PW'(1);
            case ({push, pop})
                2'b10:   occ <= occ + CW'(1);
                2'b01:   occ <= occ - CW'(1);
                default: occ <= occ;
            endcase
        end
    end

    assign head_addr = e_addr[rd_ptr];
    assign head_data = e_data[rd_ptr];
    assign head_be   = e_be[rd_ptr];

endmodule

// File: rtl/wbuf_fwd.sv
module wbuf_fwd #(
    parameter int DEPTH = 4,
    parameter int AW    = 32,
    parameter int DW    = 16,
    localparam int BW   = DW / 8,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic [AW-1:0] rd_addr,
    input  logic [PW-1:0] rd_ptr,
    input  logic [CW-1:0] occ,
    input  logic [AW-1:0] e_addr [DEPTH],
    input  logic [DW-1:0] e_data [DEPTH],
    input  logic [BW-1:0] e_be   [DEPTH],
    output logic [DW-1:0] fw_data,
    output logic [BW-1:0] fw_mask
);

    // Walk oldest to youngest so younger entries overwrite older lanes.
    always_comb begin
        logic [PW-1:0] idx;
        fw_data = '0;
        fw_mask = '0;
        for (int k = 0; k < DEPTH; k++) begin
            idx = rd_ptr + PW'(k);
            if ((CW'(k) < occ) && (e_addr[idx] == rd_addr)) begin
                for (int b = 0; b < BW; b++) begin
                    if (e_be[idx][b]) begin
                        fw_data[b*8 +: 8] = e_data[idx][b*8 +: 8];
                        fw_mask[b]        = 1'b1;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/wbuf_drain.sv
module wbuf_drain
    import wbuf_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          mem_ack,
    input  logic [CW-1:0] occ,
    output logic          mem_req,
    output logic          pop
);

    drain_state_t state, state_nx;
    logic go_busy, go_idle;

    assign go_busy = push;
    assign go_idle = mem_ack && (occ == CW'(1)) && !push;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= DR_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            DR_IDLE: if (go_busy) state_nx = DR_BUSY;
            DR_BUSY: if (go_idle) state_nx = DR_IDLE;
            default: state_nx = DR_IDLE;
        endcase
    end

    always_comb begin
        mem_req = 1'b0;
        pop     = 1'b0;
        unique case (state)
            DR_IDLE: ;
            DR_BUSY: begin
                mem_req = 1'b1;
                pop     = mem_ack;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/store_wbuf.sv
module store_wbuf #(
    parameter int DEPTH = 4,
    parameter int AW    = 32,
    parameter int DW    = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            st_valid,
    input  logic [AW-1:0]   st_addr,
    input  logic [DW-1:0]   st_data,
    input  logic [DW/8-1:0] st_be,
    output logic            st_stall,
    input  logic [AW-1:0]   rd_addr,
    output logic [DW-1:0]   rd_data,
    output logic [DW/8-1:0] rd_mask,
    output logic            mem_req,
    output logic [AW-1:0]   mem_addr,
    output logic [DW-1:0]   mem_data,
    output logic [DW/8-1:0] mem_be,
    input  logic            mem_ack
);

    localparam int BW = DW / 8;
    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic          push, pop;
    logic [CW-1:0] occ;
    logic [PW-1:0] rd_ptr;
    logic [AW-1:0] e_addr [DEPTH];
    logic [DW-1:0] e_data [DEPTH];
    logic [BW-1:0] e_be   [DEPTH];

    // A slot freed by this cycle's acknowledge may be refilled at once.
    assign st_stall = (occ == CW'(DEPTH)) && !pop;
    assign push     = st_valid && !st_stall;

    wbuf_fifo #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .pop       (pop),
        .in_addr   (st_addr),
        .in_data   (st_data),
        .in_be     (st_be),
        .head_addr (mem_addr),
        .head_data (mem_data),
        .head_be   (mem_be),
        .occ       (occ),
        .rd_ptr    (rd_ptr),
        .e_addr    (e_addr),
        .e_data    (e_data),
        .e_be      (e_be)
    );

    wbuf_drain #(.DEPTH(DEPTH)) u_drain (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (push),
        .mem_ack (mem_ack),
        .occ     (occ),
        .mem_req (mem_req),
        .pop     (pop)
    );

    wbuf_fwd #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_fwd (
        .rd_addr (rd_addr),
        .rd_ptr  (rd_ptr),
        .occ     (occ),
        .e_addr  (e_addr),
        .e_data  (e_data),
        .e_be    (e_be),
        .fw_data (rd_data),
        .fw_mask (rd_mask)
    );

endmodule

// File: rtl/wbuf_chk.sv
module wbuf_chk #(
    parameter int DEPTH = 4,
    parameter int AW    = 32,
    parameter int DW    = 16,
    localparam int BW   = DW / 8,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          st_valid,
    input logic          st_stall,
    input logic          mem_req,
    input logic          mem_ack,
    input logic [AW-1:0] mem_addr,
    input logic [DW-1:0] mem_data,
    input logic [BW-1:0] mem_be,
    input logic [CW-1:0] occ
);

    AST_HOLD_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_data) && $stable(mem_be))); // R3

    AST_POP_ONLY_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (occ >= $past(occ))); // R3

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        ((occ == CW'(DEPTH)) && !(mem_req && mem_ack)) |-> st_stall); // R4

    AST_NO_FALSE_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (occ < CW'(DEPTH)) |-> !st_stall); // R4

    AST_START_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        ((occ == '0) && st_valid) |=> mem_req); // R6

    AST_FULL_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
        ((occ == CW'(DEPTH)) && st_valid && mem_req && mem_ack) |=> (occ == CW'(DEPTH))); // R8

    AST_REQ_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (occ != '0)); // R9

    AST_OCC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= CW'(DEPTH)); // R4

endmodule

bind store_wbuf wbuf_chk #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .st_valid (st_valid),
    .st_stall (st_stall),
    .mem_req  (mem_req),
    .mem_ack  (mem_ack),
    .mem_addr (mem_addr),
    .mem_data (mem_data),
    .mem_be   (mem_be),
    .occ      (occ)
);

// File: tb/store_wbuf_test.sv
module store_wbuf_test;

    localparam int DEPTH = 4;
    localparam int AW    = 32;
    localparam int DW    = 16;
    localparam int BW    = DW / 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          st_valid;
    logic [AW-1:0] st_addr;
    logic [DW-1:0] st_data;
    logic [BW-1:0] st_be;
    logic          st_stall;
    logic [AW-1:0] rd_addr;
    logic [DW-1:0] rd_data;
    logic [BW-1:0] rd_mask;
    logic          mem_req;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_data;
    logic [BW-1:0] mem_be;
    logic          mem_ack;

    always #4 clk = ~clk;

    store_wbuf #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) uut (.*);

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    bit ack_en = 1'b0;
    int wcnt   = 0;
    int prev_n = 0;
    bit last_stall;

    logic [AW-1:0] qa [$];
    logic [DW-1:0] qd [$];
    logic [BW-1:0] qb [$];

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [BW+DW-1:0] fwd_exp(input logic [AW-1:0] a);
        logic [DW-1:0] d = '0;
        logic [BW-1:0] m = '0;
        for (int i = 0; i < qa.size(); i++) begin
            if (qa[i] == a) begin
                for (int b = 0; b < BW; b++) begin
                    if (qb[i][b]) begin
                        d[b*8 +: 8] = qd[i][b*8 +: 8];
                        m[b]        = 1'b1;
                    end
                end
            end
        end
        return {m, d};
    endfunction

    task automatic cycle(input bit sv, input logic [AW-1:0] a, input logic [DW-1:0] d,
                         input logic [BW-1:0] b, input logic [AW-1:0] ra);
        bit ack;
        bit exp_stall;
        int n;
        logic [BW+DW-1:0] fx;
        @(negedge clk);
        ack = 1'b0;
        if (mem_req && ack_en) begin
            if (wcnt == 0) begin
                ack  = 1'b1;
                wcnt = $urandom_range(0, 5);
            end else begin
                wcnt--;
            end
        end
        st_valid = sv;
        st_addr  = a;
        st_data  = d;
        st_be    = b;
        rd_addr  = ra;
        mem_ack  = ack;
        #1;
        n         = qa.size();
        exp_stall = (n == DEPTH) && !ack;
        chk(mem_req == (n != 0), (n != 0 && prev_n == 0) ? "R6" : "R9", "mem_req",
            32'(mem_req), 32'(n != 0));
        chk(st_stall == exp_stall, "R4", "st_stall", 32'(st_stall), 32'(exp_stall));
        if (n != 0) begin
            chk(mem_addr == qa[0], "R2", "mem_addr", mem_addr, qa[0]);
            chk(mem_data == qd[0], "R3", "mem_data", 32'(mem_data), 32'(qd[0]));
            chk(mem_be == qb[0], "R5", "mem_be", 32'(mem_be), 32'(qb[0]));
        end
        fx = fwd_exp(ra);
        chk({rd_mask, rd_data} == fx, "R7", "rd_mask/rd_data", 32'({rd_mask, rd_data}), 32'(fx));
        last_stall = st_stall;
        prev_n     = n;
        if (ack && n != 0) begin
            void'(qa.pop_front());
            void'(qd.pop_front());
            void'(qb.pop_front());
        end
        if (sv && !exp_stall) begin
            qa.push_back(a);
            qd.push_back(d);
            qb.push_back(b);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2718));
        rst_n    = 1'b0;
        st_valid = 1'b0;
        st_addr  = '0;
        st_data  = '0;
        st_be    = '0;
        rd_addr  = 32'h40;
        mem_ack  = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        chk(mem_req == 1'b0, "R1", "mem_req in reset", 32'(mem_req), 32'd0);
        chk(st_stall == 1'b0, "R1", "st_stall in reset", 32'(st_stall), 32'd0);
        chk(rd_mask == '0, "R1", "rd_mask in reset", 32'(rd_mask), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk(mem_req == 1'b0, "R1", "mem_req after reset", 32'(mem_req), 32'd0);

        // Directed: fill with memory stalled, overlapping lanes on one word.
        ack_en = 1'b0;
        cycle(1'b1, 32'h40, 16'h1111, 2'b01, 32'h40);
        cycle(1'b0, 32'h0,  16'h0,    2'b00, 32'h40);
        chk(mem_req == 1'b1, "R6", "request after first store", 32'(mem_req), 32'd1);
        cycle(1'b1, 32'h40, 16'h2222, 2'b10, 32'h40);
        cycle(1'b1, 32'h41, 16'h3333, 2'b11, 32'h40);
        cycle(1'b1, 32'h40, 16'h4444, 2'b01, 32'h40);
        cycle(1'b1, 32'h42, 16'h5555, 2'b11, 32'h40);
        chk(last_stall == 1'b1, "R4", "stall when full", 32'(last_stall), 32'd1);
        cycle(1'b0, 32'h0, 16'h0, 2'b00, 32'h40);
        chk({rd_mask, rd_data} == {2'b11, 16'h2244}, "R7", "merged forward",
            32'({rd_mask, rd_data}), 32'h32244);

        // Full queue: acknowledge and new store in the same cycle.
        ack_en = 1'b1;
        wcnt   = 0;
        cycle(1'b1, 32'h43, 16'h6666, 2'b11, 32'h43);
        chk(last_stall == 1'b0, "R8", "push accepted with ack", 32'(last_stall), 32'd0);
        ack_en = 1'b0;
        cycle(1'b1, 32'h42, 16'h7777, 2'b11, 32'h43);
        chk(last_stall == 1'b1, "R8", "still full after swap", 32'(last_stall), 32'd1);

        // Random traffic faster than memory drains.
        ack_en = 1'b1;
        wcnt   = $urandom_range(0, 5);
        for (int i = 0; i < 3000; i++) begin
            cycle($urandom_range(0, 99) < 60,
                  32'h40 + 32'($urandom_range(0, 3)),
                  16'($urandom()),
                  2'($urandom_range(1, 3)),
                  32'h40 + 32'($urandom_range(0, 3)));
        end

        // Drain to empty.
        for (int i = 0; i < 60; i++) cycle(1'b0, 32'h0, 16'h0, 2'b00, 32'h41);
        chk(qa.size() == 0, "R9", "reference queue empty", 32'(qa.size()), 32'd0);
        chk(mem_req == 1'b0, "R9", "request low when empty", 32'(mem_req), 32'd0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule